// File: doc/BRIEF.md
# Free-Running Microsecond System Timer

This block is a free-running up-counter that lets software measure short intervals, from a few microseconds up to about a quarter of a second, without using CPU timing instructions. A fixed prescaler divides the system clock by 42. Every prescaler period the 16-bit count advances by one. With a 10.738635 MHz clock each count is about 3.911 us.

The CPU reaches the timer through a byte-wide I/O port interface. A read of the low port (0xE6) returns count bits 7..0, and a read of the high port (0xE7) returns bits 15..8. A write of any value to the low port sets both the count and the prescaler phase to zero. The two byte reads are deliberately not protected by a snapshot latch. If the counter advances between them, software sees a torn value and must deal with it.

A small bus-response state machine produces registered read data. Its states are `S_IDLE` (bus not driven), `S_DRIVE_LO` (low byte on the bus) and `S_DRIVE_HI` (high byte on the bus). On every clock the machine moves to `S_DRIVE_LO` when a read of 0xE6 is sampled, to `S_DRIVE_HI` when a read of 0xE7 is sampled, and to `S_IDLE` otherwise. Any state can go to any state. Each read therefore drives the bus for exactly one cycle.

Top module: `usec_timer`

## Requirements
- R1: After reset the count and the prescaler phase are zero, `io_oe` is 0 and `io_rdata` is 0x00.
- R2: With no clear, the count increments by exactly one every DIV clock cycles (DIV defaults to 42) and is otherwise unchanged.
- R3: A write (`io_wr`=1) to address 0xE6 clears the count and the prescaler phase, whatever the value on `io_wdata`. The first increment after that comes 42 clocks later, so a read sampled 42 edges after the clear returns 0 and one sampled 43 edges after returns 1.
- R4: A read (`io_rd`=1) of address 0xE6 sampled at a clock edge puts count bits 7..0, as held just before that edge, on `io_rdata`, with `io_oe`=1 for the following cycle only.
- R5: A read of address 0xE7 returns count bits 15..8 in the same way, with the upper bits zero when the count is narrower than 16 bits.
- R6: No latch joins the two byte reads. A low read of 0xFF followed by a high read after an increment returns the high byte of the new value (the pair 0x01/0xFF for a count that went from 0x0FF to 0x100).
- R7: From all ones the count wraps to zero on the next increment, with no other indication.
- R8: Accesses to any address other than 0xE6 and 0xE7 leave `io_oe`=0 and `io_rdata`=0x00. Writes to 0xE7 and to other addresses do not change the count or the prescaler phase.
- R9: A clear that falls on the same edge as a prescaler increment wins, and the count is zero after that edge. A read and a clear sampled together return the value held before the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | ADDR_W (8) | I/O port address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write data (value ignored; only the write itself matters) |
| io_rdata | output | 8 | Registered read data, zero when not driving |
| io_oe | output | 1 | High for the one cycle in which `io_rdata` carries a read result |

## Verification
Two pairs of functions can fall on the same clock edge: a clear with a prescaler increment, and a byte read with an increment. The bench lines up a clear write on exactly the 42nd edge after an earlier clear. It then checks that reads 42 and 43 edges later return 0 and 1, which shows that the increment was lost and the phase restarted. A narrow, fast-dividing second instance places the high-byte read on the edge right after the low byte rolls over, which gives the expected torn pair and a silent wrap. Random traffic, mixing reads, clears and stray addresses, is compared cycle by cycle against a bench model built from the requirements.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_DRIVE_LO = 2'd1,
        S_DRIVE_HI = 2'd2
    } bus_state_e;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_RD_LO = 2'd1,
        ACC_RD_HI = 2'd2
    } access_e;

endpackage

// File: rtl/usec_timer_prescaler.sv
module usec_timer_prescaler #(
    parameter int DIV = 42
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] phase_q;

    assign tick_o = (phase_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart_i || tick_o) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/usec_timer_counter.sv
module usec_timer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clear_i) begin
            count_o <= '0;
        end else if (step_i) begin
            count_o <= count_o + 1'b1;
        end
    end
endmodule

// File: rtl/usec_timer_busport.sv
module usec_timer_busport
    import usec_timer_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'hE6,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'hE7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     io_addr,
    input  logic                  io_rd,
    input  logic                  io_wr,
    input  logic [2*BYTE_W-1:0]   value_i,
    output logic                  clear_o,
    output logic [BYTE_W-1:0]     io_rdata,
    output logic                  io_oe
);
    access_e    acc;
    bus_state_e state_q;
    bus_state_e state_d;

    assign clear_o = io_wr && (io_addr == LO_ADDR);

    always_comb begin
        acc = ACC_NONE;
        if (io_rd && (io_addr == LO_ADDR)) begin
            acc = ACC_RD_LO;
        end else if (io_rd && (io_addr == HI_ADDR)) begin
            acc = ACC_RD_HI;
        end
    end

    always_comb begin
        unique case (acc)
            ACC_RD_LO: state_d = S_DRIVE_LO;
            ACC_RD_HI: state_d = S_DRIVE_HI;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_rdata <= '0;
        end else begin
            unique case (state_d)
                S_DRIVE_LO: io_rdata <= value_i[BYTE_W-1:0];
                S_DRIVE_HI: io_rdata <= value_i[2*BYTE_W-1:BYTE_W];
                default:    io_rdata <= '0;
            endcase
        end
    end

    assign io_oe = (state_q != S_IDLE);
endmodule

// File: rtl/usec_timer.sv
module usec_timer
    import usec_timer_pkg::*;
#(
    parameter int                DIV     = 42,
    parameter int                CNT_W   = 16,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'hE6,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'hE7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_oe
);
    localparam int EXT_W = 2 * BYTE_W;

    logic             clr_w;
    logic             tick_w;
    logic [CNT_W-1:0] cnt_w;
    logic [EXT_W-1:0] cnt_ext;

    // Write data carries no meaning: any value clears.
    logic unused_wdata;
    assign unused_wdata = ^io_wdata;

    assign cnt_ext = EXT_W'(cnt_w);

    usec_timer_prescaler #(.DIV(DIV)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (clr_w),
        .tick_o    (tick_w)
    );

    usec_timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clr_w),
        .step_i  (tick_w),
        .count_o (cnt_w)
    );

    usec_timer_busport #(
        .ADDR_W  (ADDR_W),
        .LO_ADDR (LO_ADDR),
        .HI_ADDR (HI_ADDR)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .value_i  (cnt_ext),
        .clear_o  (clr_w),
        .io_rdata (io_rdata),
        .io_oe    (io_oe)
    );
endmodule

// File: rtl/usec_timer_chk.sv
module usec_timer_chk #(
    parameter int                DIV     = 42,
    parameter int                CNT_W   = 16,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] LO_ADDR = 8'hE6,
    parameter logic [ADDR_W-1:0] HI_ADDR = 8'hE7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [7:0]        io_rdata,
    input logic              io_oe,
    input logic [CNT_W-1:0]  cnt,
    input logic              tick
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    // R3: a write to the low port leaves the count at zero
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == LO_ADDR) |=> (cnt == '0));

    // R2: without a clear the count holds or advances by one
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == LO_ADDR) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

    // R2: the count moves only on a prescaler tick
    p_step_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(io_wr && io_addr == LO_ADDR)) |=> (cnt == $past(cnt)));

    // R7: all ones advances to zero
    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == ALL_ONES && tick) |=> (cnt == '0));

    // R4: low-byte read returns the pre-edge low byte
    p_read_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == LO_ADDR) |=> (io_oe && io_rdata == $past(cnt[7:0])));

    // R5: high-byte read returns the pre-edge upper bits
    p_read_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == HI_ADDR) |=> (io_oe && io_rdata == 8'($past(cnt) >> 8)));

    // R8: no read of a timer port means no drive
    p_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && (io_addr == LO_ADDR || io_addr == HI_ADDR)) |=> (!io_oe && io_rdata == 8'h00));
endmodule

bind usec_timer usec_timer_chk #(
    .DIV     (DIV),
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W),
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_rdata (io_rdata),
    .io_oe    (io_oe),
    .cnt      (cnt_w),
    .tick     (tick_w)
);

// File: tb/usec_timer_tb.sv
module usec_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_A = 42;
    localparam int DIV_B = 3;
    localparam int W_B   = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] a_addr = 8'h00, b_addr = 8'h00;
    logic a_rd = 0, a_wr = 0, b_rd = 0, b_wr = 0;
    logic [7:0] a_wd = 8'h00, b_wd = 8'h00;
    logic [7:0] a_rdata, b_rdata;
    logic a_oe, b_oe;

    int n_tests = 0;
    int n_fail  = 0;

    usec_timer u_dut (
        .clk(clk), .rst_n(rst_n), .io_addr(a_addr), .io_rd(a_rd), .io_wr(a_wr),
        .io_wdata(a_wd), .io_rdata(a_rdata), .io_oe(a_oe)
    );

    usec_timer #(.DIV(DIV_B), .CNT_W(W_B)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .io_addr(b_addr), .io_rd(b_rd), .io_wr(b_wr),
        .io_wdata(b_wd), .io_rdata(b_rdata), .io_oe(b_oe)
    );

    // Requirement model for the default instance
    int m_pre = 0;
    int m_cnt = 0;
    logic [7:0] m_rdata = 8'h00;
    logic m_oe = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre <= 0; m_cnt <= 0; m_rdata <= 8'h00; m_oe <= 1'b0;
        end else begin
            m_oe    <= a_rd && (a_addr == 8'hE6 || a_addr == 8'hE7);
            m_rdata <= !a_rd ? 8'h00 :
                       (a_addr == 8'hE6) ? 8'(m_cnt) :
                       (a_addr == 8'hE7) ? 8'(m_cnt >> 8) : 8'h00;
            if (a_wr && a_addr == 8'hE6) begin
                m_pre <= 0; m_cnt <= 0;
            end else if (m_pre == DIV_A - 1) begin
                m_pre <= 0; m_cnt <= (m_cnt + 1) % 65536;
            end else begin
                m_pre <= m_pre + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cyc_a(input logic [7:0] addr, input logic rd, input logic wr, input logic [7:0] d);
        a_addr = addr; a_rd = rd; a_wr = wr; a_wd = d;
        b_rd = 0; b_wr = 0;
        @(negedge clk);
    endtask

    task automatic cyc_b(input logic [7:0] addr, input logic rd, input logic wr, input logic [7:0] d);
        b_addr = addr; b_rd = rd; b_wr = wr; b_wd = d;
        a_rd = 0; a_wr = 0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            a_rd = 0; a_wr = 0; b_rd = 0; b_wr = 0;
            @(negedge clk);
        end
    endtask

    task automatic chk_model(input string req);
        chk({req, " oe"}, {7'd0, a_oe}, {7'd0, m_oe});
        chk({req, " data"}, a_rdata, m_rdata);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 oe", {7'd0, a_oe}, 8'h00);
        chk("R1 rdata", a_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        cyc_a(8'hE6, 1, 0, 8'h00);
        chk("R1 count after reset", a_rdata, 8'h00);

        // R3: clear with arbitrary data, first tick 42 edges later
        cyc_a(8'hE6, 0, 1, 8'hA5);
        idle(41);
        cyc_a(8'hE6, 1, 0, 8'h00);
        chk("R3 edge 42 low", a_rdata, 8'h00);
        cyc_a(8'hE6, 1, 0, 8'h00);
        chk("R3 edge 43 low", a_rdata, 8'h01);
        chk("R4 oe during read", {7'd0, a_oe}, 8'h01);
        idle(1);
        chk("R4 oe one cycle", {7'd0, a_oe}, 8'h00);

        // R2: several prescaler periods
        idle(42 * 5);
        cyc_a(8'hE6, 1, 0, 8'h00);
        chk_model("R2 after periods");
        chk("R2 value", a_rdata, 8'h06);

        // R8: stray addresses and writes to high port
        cyc_a(8'hE7, 0, 1, 8'hFF);
        cyc_a(8'h10, 1, 0, 8'h00);
        chk("R8 stray read oe", {7'd0, a_oe}, 8'h00);
        chk("R8 stray read data", a_rdata, 8'h00);
        cyc_a(8'h55, 0, 1, 8'h00);
        cyc_a(8'hE6, 1, 0, 8'h00);
        chk_model("R8 no clear by high write");
        chk("R8 count kept", a_rdata, 8'h06);

        // R9: clear on the same edge as a tick
        cyc_a(8'hE6, 0, 1, 8'h00);
        idle(41);
        cyc_a(8'hE6, 0, 1, 8'h3C);
        idle(41);
        cyc_a(8'hE6, 1, 0, 8'h00);
        chk("R9 clear beats tick", a_rdata, 8'h00);
        cyc_a(8'hE6, 1, 0, 8'h00);
        chk("R9 phase restarted", a_rdata, 8'h01);
        // R9: read and clear together return the old value
        idle(42 * 3);
        cyc_a(8'hE6, 1, 1, 8'h00);
        chk("R9 read with clear", a_rdata, 8'h04);
        cyc_a(8'hE6, 1, 0, 8'h00);
        chk("R9 cleared after", a_rdata, 8'h00);

        // R6 and R7 on the narrow instance (DIV 3, 10-bit count)
        cyc_b(8'hE6, 0, 1, 8'h77);
        idle(767);
        cyc_b(8'hE6, 1, 0, 8'h00);
        chk("R6 torn low", b_rdata, 8'hFF);
        cyc_b(8'hE7, 1, 0, 8'h00);
        chk("R6 torn high", b_rdata, 8'h01);
        chk("R5 high oe", {7'd0, b_oe}, 8'h01);
        idle(3071 - 769);
        cyc_b(8'hE7, 1, 0, 8'h00);
        chk("R7 high before wrap", b_rdata, 8'h03);
        cyc_b(8'hE6, 1, 0, 8'h00);
        chk("R7 low after wrap", b_rdata, 8'h00);
        cyc_b(8'hE7, 1, 0, 8'h00);
        chk("R7 high after wrap", b_rdata, 8'h00);

        // R4 R5 R8 R9: random traffic on the default instance
        for (int i = 0; i < 3000; i++) begin
            int sel;
            logic [7:0] ad;
            sel = $urandom_range(0, 9);
            ad = (sel < 4) ? 8'hE6 : (sel < 8) ? 8'hE7 : 8'($urandom_range(0, 255));
            cyc_a(ad, ($urandom_range(0, 2) != 0), ($urandom_range(0, 40) == 0), 8'($urandom()));
            chk_model("R4 R5 R8 random");
        end
        idle(2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule